// File: doc/BRIEF.md
# Multibank SDRAM Command Sequencer

This block sits on the controller side of a four-bank double-data-rate SDRAM and turns simple access requests into the command stream the memory expects. Each request names a bank, a row and a starting column, says whether it is a read or a write, picks a burst length, and may ask for the row to be closed automatically once the burst is over. The sequencer remembers, for every bank on its own, whether a row is open and which one it is. It then sends only the commands the access needs. A row miss costs a Precharge and an Active. A closed bank costs an Active. A row hit goes straight to the column command.

At most one command leaves per clock, from a register, so every command is aligned to the rising clock edge. For reads the block raises a window flag during the clock cycles in which read data is due on the bus. That timing follows from the fixed CAS latency of three clocks and from the burst length, which moves two data words per clock. Requests come in through a ready/valid handshake that can hold one request at a time. A request aimed at a bank that is still closing itself after an auto-precharge access stays parked until that bank is free.

Top module: `sdram_cmd_seq`

## Requirements
- R1: After reset, the command output is NOP (code 0) with bank 0, address 0 and the auto-precharge flag low. All bank_open bits are 0, rd_window is 0 and req_ready is 1.
- R2: Command codes are NOP=0, ACT=1, RD=2, WR=3 and PRE=4. A request to a closed bank produces ACT carrying the row on the edge after acceptance. RD (or WR) carrying the column follows on the next edge.
- R3: A request to the row that is already open in its bank skips ACT. The column command goes out on the edge after acceptance, provided the spacing rule of R11 allows it.
- R4: A request to a bank that has a different row open produces PRE, then ACT, then the column command, on three consecutive edges after acceptance.
- R5: Each bank keeps its own open/closed state and open row. bank_open[b] is 1 exactly while bank b has a row open.
- R6: After a RD is issued, rd_window is high from 3 cycles (the CAS latency) after the command cycle, for burst-length/2 cycles, then low again unless another read extends it.
- R7: req_burst selects the burst length: 0 gives 2, 1 gives 4, and 2 or 3 give 8. The selection is captured with the request.
- R8: With req_autopre set, the column command carries cmd_autopre=1 and no PRE is ever issued for it. The bank reads as closed starting CAS+BL/2 cycles after a RD, or 1+BL/2 cycles after a WR.
- R9: While a bank is closing itself, a request to that bank waits. On the edge where the bank closes, ACT for the waiting request may issue, and the bank stays open.
- R10: req_ready is 1 only when the single request slot is empty. It falls on the edge that accepts a request and returns on the edge that issues that request's column command.
- R11: Two column commands (RD or WR) are at least BL/2 cycles apart, where BL is the burst length of the earlier one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all commands change on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A request is offered |
| req_ready | output | 1 | The request slot is empty |
| req_write | input | 1 | 1 = write access, 0 = read access |
| req_bank | input | 2 | Target bank |
| req_row | input | 13 | Target row |
| req_col | input | 10 | Starting column |
| req_autopre | input | 1 | Close the row automatically after the burst |
| req_burst | input | 2 | Burst length select (R7) |
| cmd_code | output | 3 | Command issued this cycle (R2 encoding) |
| cmd_bank | output | 2 | Bank addressed by the command |
| cmd_addr | output | 13 | Row for ACT, column for RD/WR, 0 otherwise |
| cmd_autopre | output | 1 | Auto-precharge flag on RD/WR |
| rd_window | output | 1 | Read data is expected on the bus this cycle |
| bank_open | output | 4 | Per-bank open-row flags |

## Verification
The end of a self-timed auto precharge and the opening of the same bank for a new request can fall on the same clock edge. The bench sets this up by offering a request to the same bank, on a different row or the same row, right after an auto-precharge access. The request is then parked until the bank closes. A behavioural reference model, stepped on every clock, predicts the ACT on exactly the closing edge and expects that bank's open flag to stay high across it. A second overlap, back-to-back burst-of-eight row hits, checks that the column spacing and the read window line up.

// File: rtl/sdram_seq_pkg.sv
package sdram_seq_pkg;

  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_ACT = 3'd1,
    CMD_RD  = 3'd2,
    CMD_WR  = 3'd3,
    CMD_PRE = 3'd4
  } cmd_e;

  // Clock cycles occupied by one burst on the bus (two words per clock).
  function automatic int unsigned burst_clks(input logic [1:0] sel);
    case (sel)
      2'd0:    return 1;
      2'd1:    return 2;
      default: return 4;
    endcase
  endfunction

  // Cycles from a column command with auto precharge until the bank is closed.
  function automatic int unsigned ap_hold(input logic [1:0] sel, input logic is_read,
                                          input int unsigned cas);
    if (is_read) return cas + burst_clks(sel);
    return 1 + burst_clks(sel);
  endfunction

endpackage

// File: rtl/sdram_bank_state.sv
module sdram_bank_state #(
  parameter int ROW_W = 13,
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             act_fire,
  input  logic [ROW_W-1:0] act_row,
  input  logic             pre_fire,
  input  logic             ap_fire,
  input  logic [CNT_W-1:0] ap_len,
  output logic             open_o,
  output logic [ROW_W-1:0] row_o,
  output logic             busy_o,
  output logic             expire_o
);

  logic             open_q;
  logic [ROW_W-1:0] row_q;
  logic [CNT_W-1:0] ap_cnt_q;

  assign open_o   = open_q;
  assign row_o    = row_q;
  assign busy_o   = (ap_cnt_q != '0);
  assign expire_o = (ap_cnt_q == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      row_q  <= '0;
    end else if (act_fire) begin
      open_q <= 1'b1;
      row_q  <= act_row;
    end else if (pre_fire || expire_o) begin
      open_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)              ap_cnt_q <= '0;
    else if (ap_fire)        ap_cnt_q <= ap_len;
    else if (ap_cnt_q != '0) ap_cnt_q <= ap_cnt_q - CNT_W'(1);
  end

  a_r9_expire_closes: assert property (@(posedge clk) disable iff (!rst_n)
    (expire_o && !act_fire) |=> !open_q);

  a_r2_act_opens_row: assert property (@(posedge clk) disable iff (!rst_n)
    act_fire |=> (open_q && row_q == $past(act_row)));

  a_r8_ap_marks_busy: assert property (@(posedge clk) disable iff (!rst_n)
    ap_fire |=> busy_o);

endmodule

// File: rtl/sdram_rd_window.sv
module sdram_rd_window
  import sdram_seq_pkg::*;
#(
  parameter int CAS_LAT  = 3,
  parameter int MAX_BCLK = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rd_fire,
  input  logic [1:0] burst_sel,
  output logic       win_o
);

  localparam int DEPTH = CAS_LAT + MAX_BCLK;

  logic [DEPTH-1:0] sr_q;
  logic [DEPTH-1:0] mask;

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      mask[i] = (i >= CAS_LAT) && (i < CAS_LAT + int'(burst_clks(burst_sel)));
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= (sr_q >> 1) | (rd_fire ? mask : '0);
  end

  assign win_o = sr_q[0];

  a_r6_no_window_without_read: assert property (@(posedge clk) disable iff (!rst_n)
    (sr_q == '0 && !rd_fire) |=> !win_o);

endmodule

// File: rtl/sdram_cmd_seq.sv
module sdram_cmd_seq
  import sdram_seq_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int ROW_W     = 13,
  parameter int COL_W     = 10,
  parameter int CAS_LAT   = 3
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         req_valid,
  output logic                         req_ready,
  input  logic                         req_write,
  input  logic [$clog2(NUM_BANKS)-1:0] req_bank,
  input  logic [ROW_W-1:0]             req_row,
  input  logic [COL_W-1:0]             req_col,
  input  logic                         req_autopre,
  input  logic [1:0]                   req_burst,
  output logic [2:0]                   cmd_code,
  output logic [$clog2(NUM_BANKS)-1:0] cmd_bank,
  output logic [((ROW_W > COL_W) ? ROW_W : COL_W)-1:0] cmd_addr,
  output logic                         cmd_autopre,
  output logic                         rd_window,
  output logic [NUM_BANKS-1:0]         bank_open
);

  localparam int BANK_W   = $clog2(NUM_BANKS);
  localparam int ADDR_W   = (ROW_W > COL_W) ? ROW_W : COL_W;
  localparam int MAX_BCLK = 4;
  localparam int CNT_W    = $clog2(CAS_LAT + MAX_BCLK + 1);
  localparam int GAP_W    = $clog2(MAX_BCLK + 1);

  // Single request slot
  logic              pend_v;
  logic              pend_wr;
  logic [BANK_W-1:0] pend_bank;
  logic [ROW_W-1:0]  pend_row;
  logic [COL_W-1:0]  pend_col;
  logic              pend_ap;
  logic [1:0]        pend_bs;

  // Per-bank tracker outputs
  logic [NUM_BANKS-1:0] open_w, busy_w, expire_w;
  logic [ROW_W-1:0]     row_w [NUM_BANKS];
  logic [NUM_BANKS-1:0] act_fire, pre_fire, ap_fire;

  // Named internal events
  logic tgt_open, tgt_busy, row_hit, gap_clear;
  logic col_issue, req_take;
  cmd_e nxt_cmd;
  logic [CNT_W-1:0] ap_len;
  logic [GAP_W-1:0] gap_q;

  cmd_e              cmd_q;
  logic [BANK_W-1:0] bank_q;
  logic [ADDR_W-1:0] addr_q;
  logic              ap_q;

  assign req_ready = !pend_v;
  assign req_take  = req_valid && req_ready;

  assign tgt_open  = open_w[pend_bank] && !expire_w[pend_bank];
  assign tgt_busy  = busy_w[pend_bank] && !expire_w[pend_bank];
  assign row_hit   = (row_w[pend_bank] == pend_row);
  assign gap_clear = (gap_q == '0);

  always_comb begin
    nxt_cmd = CMD_NOP;
    if (pend_v && !tgt_busy) begin
      if (tgt_open && !row_hit) nxt_cmd = CMD_PRE;
      else if (!tgt_open)       nxt_cmd = CMD_ACT;
      else if (gap_clear)       nxt_cmd = pend_wr ? CMD_WR : CMD_RD;
    end
  end

  assign col_issue = (nxt_cmd == CMD_RD) || (nxt_cmd == CMD_WR);
  assign ap_len    = CNT_W'(ap_hold(pend_bs, !pend_wr, CAS_LAT));

  genvar g;
  generate
    for (g = 0; g < NUM_BANKS; g++) begin : g_bank
      assign act_fire[g] = (nxt_cmd == CMD_ACT) && (pend_bank == BANK_W'(g));
      assign pre_fire[g] = (nxt_cmd == CMD_PRE) && (pend_bank == BANK_W'(g));
      assign ap_fire[g]  = col_issue && pend_ap && (pend_bank == BANK_W'(g));

      sdram_bank_state #(
        .ROW_W (ROW_W),
        .CNT_W (CNT_W)
      ) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .act_fire (act_fire[g]),
        .act_row  (pend_row),
        .pre_fire (pre_fire[g]),
        .ap_fire  (ap_fire[g]),
        .ap_len   (ap_len),
        .open_o   (open_w[g]),
        .row_o    (row_w[g]),
        .busy_o   (busy_w[g]),
        .expire_o (expire_w[g])
      );
    end
  endgenerate

  // Request slot
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_v    <= 1'b0;
      pend_wr   <= 1'b0;
      pend_bank <= '0;
      pend_row  <= '0;
      pend_col  <= '0;
      pend_ap   <= 1'b0;
      pend_bs   <= '0;
    end else if (col_issue) begin
      pend_v <= 1'b0;
    end else if (req_take) begin
      pend_v    <= 1'b1;
      pend_wr   <= req_write;
      pend_bank <= req_bank;
      pend_row  <= req_row;
      pend_col  <= req_col;
      pend_ap   <= req_autopre;
      pend_bs   <= req_burst;
    end
  end

  // Column command spacing
  always_ff @(posedge clk) begin
    if (!rst_n)              gap_q <= '0;
    else if (col_issue)      gap_q <= GAP_W'(burst_clks(pend_bs) - 1);
    else if (gap_q != '0)    gap_q <= gap_q - GAP_W'(1);
  end

  // Registered command outputs
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q  <= CMD_NOP;
      bank_q <= '0;
      addr_q <= '0;
      ap_q   <= 1'b0;
    end else begin
      cmd_q  <= nxt_cmd;
      bank_q <= (nxt_cmd == CMD_NOP) ? '0 : pend_bank;
      ap_q   <= col_issue && pend_ap;
      if (nxt_cmd == CMD_ACT)  addr_q <= ADDR_W'(pend_row);
      else if (col_issue)      addr_q <= ADDR_W'(pend_col);
      else                     addr_q <= '0;
    end
  end

  sdram_rd_window #(
    .CAS_LAT  (CAS_LAT),
    .MAX_BCLK (MAX_BCLK)
  ) u_rdwin (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_fire   (nxt_cmd == CMD_RD),
    .burst_sel (pend_bs),
    .win_o     (rd_window)
  );

  assign cmd_code    = cmd_q;
  assign cmd_bank    = bank_q;
  assign cmd_addr    = addr_q;
  assign cmd_autopre = ap_q;
  assign bank_open   = open_w;

  a_r2_col_to_open_bank: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_code == CMD_RD || cmd_code == CMD_WR) |-> bank_open[cmd_bank]);

  a_r4_pre_closes_bank: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_code == CMD_PRE) |-> !bank_open[cmd_bank]);

  a_r10_slot_fills: assert property (@(posedge clk) disable iff (!rst_n)
    req_take |=> !req_ready);

  a_r8_no_ap_on_other_cmds: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_autopre |-> (cmd_code == CMD_RD || cmd_code == CMD_WR));

endmodule

// File: tb/sdram_cmd_seq_tb.sv
module sdram_cmd_seq_tb;

  localparam int CAS = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [1:0]  req_bank = '0;
  logic [12:0] req_row = '0;
  logic [9:0]  req_col = '0;
  logic        req_autopre = 1'b0;
  logic [1:0]  req_burst = '0;
  logic [2:0]  cmd_code;
  logic [1:0]  cmd_bank;
  logic [12:0] cmd_addr;
  logic        cmd_autopre;
  logic        rd_window;
  logic [3:0]  bank_open;

  int checks = 0;
  int fails  = 0;
  bit timed_out = 1'b0;

  always #10 clk = ~clk;

  sdram_cmd_seq u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_bank(req_bank), .req_row(req_row), .req_col(req_col),
    .req_autopre(req_autopre), .req_burst(req_burst),
    .cmd_code(cmd_code), .cmd_bank(cmd_bank), .cmd_addr(cmd_addr),
    .cmd_autopre(cmd_autopre), .rd_window(rd_window), .bank_open(bank_open)
  );

  // ---------------- behavioural reference model ----------------
  int  cyc;
  bit  m_open [4];
  int  m_row [4];
  int  m_close_at [4];
  bit  m_pv, m_pwr, m_pap;
  int  m_pb, m_prow, m_pcol, m_pbs;
  int  m_last_col, m_last_gap;
  int  m_cmd, m_bank, m_addr;
  bit  m_ap;
  bit  m_win [int];

  function automatic int clks_of(int sel);
    return (sel == 0) ? 1 : (sel == 1) ? 2 : 4;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      cyc = 0;
      for (int b = 0; b < 4; b++) begin m_open[b] = 0; m_row[b] = 0; m_close_at[b] = -1; end
      m_pv = 0; m_last_col = -100; m_last_gap = 0;
      m_cmd = 0; m_bank = 0; m_addr = 0; m_ap = 0;
      m_win.delete();
    end else begin
      bit was_pending, closing, eff_open, eff_busy;
      int b;
      cyc++;
      was_pending = m_pv;
      m_cmd = 0; m_bank = 0; m_addr = 0; m_ap = 0;
      if (m_pv) begin
        b = m_pb;
        closing  = (m_close_at[b] == cyc);
        eff_open = m_open[b] && !closing;
        eff_busy = (m_close_at[b] >= 0) && !closing;
        if (!eff_busy) begin
          if (eff_open && m_row[b] != m_prow) begin m_cmd = 4; m_bank = b; end
          else if (!eff_open) begin m_cmd = 1; m_bank = b; m_addr = m_prow; end
          else if (cyc >= m_last_col + m_last_gap) begin
            m_cmd = m_pwr ? 3 : 2; m_bank = b; m_addr = m_pcol; m_ap = m_pap;
          end
        end
      end
      for (int k = 0; k < 4; k++)
        if (m_close_at[k] == cyc) begin m_open[k] = 0; m_close_at[k] = -1; end
      if (m_cmd == 4) m_open[m_pb] = 0;
      if (m_cmd == 1) begin m_open[m_pb] = 1; m_row[m_pb] = m_prow; end
      if (m_cmd == 2 || m_cmd == 3) begin
        if (m_pap)
          m_close_at[m_pb] = cyc + ((m_cmd == 2) ? CAS : 1) + clks_of(m_pbs);
        if (m_cmd == 2)
          for (int i = 0; i < clks_of(m_pbs); i++) m_win[cyc + CAS + i] = 1;
        m_last_col = cyc; m_last_gap = clks_of(m_pbs);
        m_pv = 0;
      end else if (!was_pending && req_valid) begin
        m_pv = 1; m_pwr = req_write; m_pb = req_bank; m_prow = req_row;
        m_pcol = req_col; m_pap = req_autopre; m_pbs = req_burst;
      end
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s cycle %0d actual=%0d expected=%0d", tag, cyc, act, exp);
    end
  endtask

  // Compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      bit [3:0] ov;
      for (int b = 0; b < 4; b++) ov[b] = m_open[b];
      chk("R2/R3/R4/R9/R11 cmd_code", cmd_code, m_cmd);
      chk("R2/R4 cmd_bank", cmd_bank, m_bank);
      chk("R2/R3 cmd_addr", cmd_addr, m_addr);
      chk("R8 cmd_autopre", cmd_autopre, m_ap);
      chk("R6/R7 rd_window", rd_window, m_win.exists(cyc) ? 1 : 0);
      chk("R5/R8/R9 bank_open", bank_open, ov);
      chk("R10 req_ready", req_ready, m_pv ? 0 : 1);
    end
  end

  task automatic send(bit wr, int bank, int row, int col, bit ap, int bs);
    @(negedge clk);
    req_valid = 1; req_write = wr; req_bank = 2'(bank); req_row = 13'(row);
    req_col = 10'(col); req_autopre = ap; req_burst = 2'(bs);
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic run_all();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 reset cmd", cmd_code, 0);
    chk("R1 reset open", bank_open, 0);
    chk("R1 reset window", rd_window, 0);
    chk("R1 reset ready", req_ready, 1);
    // closed bank, then hit, then miss
    send(0, 0, 5, 8, 0, 1);  idle(8);
    send(0, 0, 5, 12, 0, 1); idle(8);
    send(1, 0, 9, 4, 0, 0);  idle(8);
    // independent banks and burst-of-eight spacing
    send(0, 1, 3, 16, 0, 2);
    send(0, 2, 7, 20, 0, 2);
    send(0, 1, 3, 24, 0, 3);
    send(0, 1, 3, 28, 0, 2);
    idle(10);
    // auto precharge read, then same bank waits and meets the closing edge
    send(0, 3, 11, 32, 1, 2);
    send(0, 3, 12, 36, 0, 1);
    idle(12);
    // auto precharge write, then same row again
    send(1, 2, 7, 40, 1, 1);
    send(1, 2, 7, 44, 0, 0);
    idle(8);
    // row hit with auto precharge, then a burst of two
    send(0, 1, 3, 48, 1, 0);
    send(0, 1, 6, 52, 0, 0);
    idle(12);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (20000) @(posedge clk);
        timed_out = 1;
      end
    join_any
    disable fork;
    if (timed_out) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired actual=1 expected=0");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule